// File: doc/BRIEF.md
# Selectable-Ratio Lane Serializer

This block turns a parallel word into a serial bit stream at one bit per serial clock. A two-bit ratio select chooses how many bits form a word (4, 8, 10 or 16). Each ratio reads its own window of the 16-lane input bus, and the window is centred on the middle of the bus. Lanes outside the window are ignored. The word is loaded once per frame and shifted out most-significant lane first.

The block counts bit periods within each frame. On the last bit of a frame it raises a one-cycle read strobe toward the upstream elastic buffer. The word on the lanes at that edge becomes the next frame. It also drives a parallel-rate clock at the serial rate divided by the ratio.

Two active-low controls route the serial path. Line loopback replaces the serial data and clock outputs with an externally supplied serial pair. Diagnostic loopback copies the serialized data and clock onto a second output pair, which otherwise stays low. All control inputs treat a high level as the idle setting, so an undriven configuration gives 16:1 with both loopbacks off.

Top module: `lane_serializer`

## Requirements
- R1: Ratio select 2'b00 sends 4 bits per frame, taken from lanes 9 down to 6, with lane 9 sent first.
- R2: Ratio select 2'b01 sends 8 bits per frame, taken from lanes 11 down to 4, with lane 11 sent first.
- R3: Ratio select 2'b10 sends 10 bits per frame, taken from lanes 12 down to 3, with lane 12 sent first.
- R4: Ratio select 2'b11 sends 16 bits per frame, taken from lanes 15 down to 0, with lane 15 sent first. The serial clock output follows the bit clock while line loopback is off.
- R5: Lanes outside the selected window never affect the serial output, and neither does the lane value in any cycle other than the strobe cycle.
- R6: `fifo_rd` is high for exactly one cycle per frame, on the last bit period. The lane word present at that clock edge appears on `ser_data` from the next cycle, and the new frame begins at bit 0.
- R7: `par_clk` is high during the first floor(N/2) bit periods of each N-bit frame and low during the rest.
- R8: A change of ratio select takes effect only at the frame boundary that follows. The frame in progress keeps its length and data, and the next frame uses the new ratio from bit 0.
- R9: While `lin_loop_n` is 0, `ser_data` and `ser_clk` equal `ext_ser_data` and `ext_ser_clk`.
- R10: While `diag_loop_n` is 0, `loop_data` carries the serialized bit stream and `loop_clk` carries the bit clock. This holds regardless of line loopback. While `diag_loop_n` is 1, both outputs are 0.
- R11: While `rst_n` is 0 at a clock edge, the serializer state clears, so `ser_data` is 0 (line loopback off), `fifo_rd` is 0 and `par_clk` is 1. The ratio is taken from `ratio_sel`, and the first frame starts at the first edge with `rst_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 2 | Ratio select: 00=4, 01=8, 10=10, 11=16 bits per frame |
| par_in | input | 16 | Parallel lane bus |
| lin_loop_n | input | 1 | Line loopback enable, active low |
| diag_loop_n | input | 1 | Diagnostic loopback enable, active low |
| ext_ser_data | input | 1 | External serial data for line loopback |
| ext_ser_clk | input | 1 | External serial clock for line loopback |
| ser_data | output | 1 | Serial data output |
| ser_clk | output | 1 | Serial clock output |
| loop_data | output | 1 | Diagnostic loop data output |
| loop_clk | output | 1 | Diagnostic loop clock output |
| par_clk | output | 1 | Parallel-rate clock, serial rate divided by ratio |
| fifo_rd | output | 1 | One-cycle load/read strobe per frame |

## Verification
A ratio change and a word load can land in the same cycle. The bench provokes this by driving a new `ratio_sel` together with a new word in the very cycle where `fifo_rd` is high. It then judges the result by the length of the following frame, its `par_clk` split and the lanes it sends. The opposite case changes the select two bits into a 16-bit frame. That frame must still run all 16 bits with its original data before the shorter frame begins. Diagnostic mirroring is also checked bit by bit while frames of every ratio run.

// File: rtl/lsr_pkg.sv
// Shared constants, ratio encoding and ratio geometry for the lane serializer.
// Assumes the widest ratio uses every lane of the bus.
package lsr_pkg;
    localparam int LANES      = 16;
    localparam int NUM_RATIOS = 4;
    localparam int SEL_W      = $clog2(NUM_RATIOS);
    localparam int CNT_W      = $clog2(LANES);

    typedef enum logic [SEL_W-1:0] {
        RATIO_4  = 2'b00,
        RATIO_8  = 2'b01,
        RATIO_10 = 2'b10,
        RATIO_16 = 2'b11
    } ratio_e;

    // Bits per frame for a ratio code.
    function automatic int ratio_len(input logic [SEL_W-1:0] code);
        case (code)
            2'b00:   return 4;
            2'b01:   return 8;
            2'b10:   return 10;
            default: return LANES;
        endcase
    endfunction

    // Lowest lane of the centred window for a ratio code.
    function automatic int ratio_base(input logic [SEL_W-1:0] code);
        return (LANES - ratio_len(code)) / 2;
    endfunction
endpackage

// File: rtl/lsr_window_sel.sv
// Lane window selector: extracts the centred lane window for each ratio and
// left-aligns it so the window's top lane lands at the word's MSB.
// Assumes the select is stable around the load edge (it is sampled there).
module lsr_window_sel
    import lsr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [LANES-1:0] lanes,
    output logic [LANES-1:0] aligned
);
    logic [LANES-1:0] cand [NUM_RATIOS];

    // One left-aligned candidate word per ratio, built from its lane window.
    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
        localparam int N  = ratio_len(SEL_W'(g));
        localparam int LO = ratio_base(SEL_W'(g));
        if (N == LANES) begin : g_full
            assign cand[g] = lanes;
        end else begin : g_part
            assign cand[g] = {lanes[LO+N-1:LO], {(LANES-N){1'b0}}};
        end
    end

    // Pick the candidate of the requested ratio.
    always_comb begin
        aligned = cand[sel];
    end
endmodule

// File: rtl/lsr_frame_ctr.sv
// Frame counter: counts bit periods modulo the active ratio, raises a strobe
// on the last bit, latches a new ratio only at the frame boundary and drives
// a registered parallel-rate clock.
// Assumes the ratio input is valid in every cycle.
module lsr_frame_ctr
    import lsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic [CNT_W-1:0] cnt,
    output logic [SEL_W-1:0] ratio_act,
    output logic             frame_end,
    output logic             par_clk
);
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic [SEL_W-1:0] act_q, act_nxt;
    logic             pclk_q;
    logic             last;

    // Next-state: wrap and adopt the requested ratio at the frame's last bit.
    always_comb begin
        last    = (int'(cnt_q) == ratio_len(act_q) - 1);
        cnt_nxt = last ? '0 : cnt_q + 1'b1;
        act_nxt = last ? ratio_sel : act_q;
    end

    // State registers; parallel clock follows the next count to stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            act_q  <= ratio_sel;
            pclk_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_nxt;
            act_q  <= act_nxt;
            pclk_q <= (int'(cnt_nxt) < ratio_len(act_nxt) / 2);
        end
    end

    assign cnt       = cnt_q;
    assign ratio_act = act_q;
    assign frame_end = last;
    assign par_clk   = pclk_q;
endmodule

// File: rtl/lsr_shifter.sv
// Shift register: loads a left-aligned word and shifts it toward the MSB one
// bit per clock, presenting the MSB as the serial bit.
// Assumes words arrive already left-aligned.
module lsr_shifter
    import lsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] sh,
    output logic             bit_out
);
    logic [LANES-1:0] sh_q;

    // Load on the strobe, otherwise shift left with zero fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= din;
        end else begin
            sh_q <= {sh_q[LANES-2:0], 1'b0};
        end
    end

    assign sh      = sh_q;
    assign bit_out = sh_q[LANES-1];
endmodule

// File: rtl/lsr_loop_route.sv
// Loopback router: selects line loopback for the main serial pair and gates
// the diagnostic mirror pair. Purely combinational.
// Assumes the enables are quasi-static configuration levels.
module lsr_loop_route (
    input  logic bit_clk,
    input  logic mux_data,
    input  logic lin_loop_n,
    input  logic diag_loop_n,
    input  logic ext_data,
    input  logic ext_clk,
    output logic ser_data,
    output logic ser_clk,
    output logic loop_data,
    output logic loop_clk
);
    // Main pair: external stream replaces the serializer in line loopback.
    always_comb begin
        ser_data = lin_loop_n ? mux_data : ext_data;
        ser_clk  = lin_loop_n ? bit_clk  : ext_clk;
    end

    // Mirror pair: serializer output when enabled, held low otherwise.
    always_comb begin
        loop_data = ~diag_loop_n & mux_data;
        loop_clk  = ~diag_loop_n & bit_clk;
    end
endmodule

// File: rtl/lane_serializer.sv
// Top level of the selectable-ratio lane serializer: window selection,
// frame counting, shifting and loopback routing.
// Assumes clk is the serial bit clock and par_in is valid at the strobe edge.
module lane_serializer
    import lsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  ratio_sel,
    input  logic [15:0] par_in,
    input  logic        lin_loop_n,
    input  logic        diag_loop_n,
    input  logic        ext_ser_data,
    input  logic        ext_ser_clk,
    output logic        ser_data,
    output logic        ser_clk,
    output logic        loop_data,
    output logic        loop_clk,
    output logic        par_clk,
    output logic        fifo_rd
);
    logic [CNT_W-1:0] frame_cnt;
    logic [SEL_W-1:0] ratio_act;
    logic [LANES-1:0] win_word;
    logic [LANES-1:0] shreg;
    logic             frame_end;
    logic             mux_bit;

    lsr_frame_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .cnt       (frame_cnt),
        .ratio_act (ratio_act),
        .frame_end (frame_end),
        .par_clk   (par_clk)
    );

    lsr_window_sel u_win (
        .sel     (ratio_sel),
        .lanes   (par_in),
        .aligned (win_word)
    );

    lsr_shifter u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_end),
        .din     (win_word),
        .sh      (shreg),
        .bit_out (mux_bit)
    );

    lsr_loop_route u_route (
        .bit_clk     (clk),
        .mux_data    (mux_bit),
        .lin_loop_n  (lin_loop_n),
        .diag_loop_n (diag_loop_n),
        .ext_data    (ext_ser_data),
        .ext_clk     (ext_ser_clk),
        .ser_data    (ser_data),
        .ser_clk     (ser_clk),
        .loop_data   (loop_data),
        .loop_clk    (loop_clk)
    );

    assign fifo_rd = frame_end;
endmodule

// File: rtl/lane_serializer_chk.sv
// Protocol checker for the lane serializer, bound into the top level.
// Assumes the synchronous active-low reset is asserted at time zero.
module lane_serializer_chk
    import lsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_rd,
    input logic             par_clk,
    input logic [CNT_W-1:0] cnt,
    input logic [SEL_W-1:0] ratio_act,
    input logic [LANES-1:0] shreg
);
    assert_reset_state_R11: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && par_clk && shreg == '0));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> !fifo_rd);

    assert_restart_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> cnt == '0);

    assert_count_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < ratio_len(ratio_act));

    assert_ratio_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rd |=> $stable(ratio_act));

    assert_pclk_rise_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_clk) |-> $past(fifo_rd));

    assert_pclk_fall_at_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(par_clk) |-> int'(cnt) == ratio_len(ratio_act) / 2);

    assert_shift_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rd |=> shreg == {$past(shreg[LANES-2:0]), 1'b0});
endmodule

bind lane_serializer lane_serializer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_rd   (fifo_rd),
    .par_clk   (par_clk),
    .cnt       (frame_cnt),
    .ratio_act (ratio_act),
    .shreg     (shreg)
);

// File: tb/lane_serializer_bench.sv
module lane_serializer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    // {ratio_sel, lane word, expected left-aligned serial pattern}
    localparam logic [33:0] VEC [NVEC] = '{
        {2'b00, 16'hFC3F, 16'h0000},
        {2'b00, 16'h03C0, 16'hF000},
        {2'b00, 16'h0240, 16'h9000},
        {2'b01, 16'hF00F, 16'h0000},
        {2'b01, 16'h0A50, 16'hA500},
        {2'b10, 16'h1FF8, 16'hFFC0},
        {2'b10, 16'hE007, 16'h0000},
        {2'b10, 16'h1008, 16'h8040},
        {2'b11, 16'h8001, 16'h8001},
        {2'b11, 16'h5A3C, 16'h5A3C},
        {2'b00, 16'h0100, 16'h4000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ratio_sel;
    logic [15:0] par_in;
    logic        lin_loop_n, diag_loop_n, ext_ser_data, ext_ser_clk;
    logic        ser_data, ser_clk, loop_data, loop_clk, par_clk, fifo_rd;
    int          compared = 0;
    int          mismatched = 0;

    lane_serializer u_lane_serializer (
        .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .par_in(par_in),
        .lin_loop_n(lin_loop_n), .diag_loop_n(diag_loop_n),
        .ext_ser_data(ext_ser_data), .ext_ser_clk(ext_ser_clk),
        .ser_data(ser_data), .ser_clk(ser_clk), .loop_data(loop_data),
        .loop_clk(loop_clk), .par_clk(par_clk), .fifo_rd(fifo_rd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bits_for(input logic [1:0] s);
        case (s)
            2'b00:   return 4;
            2'b01:   return 8;
            2'b10:   return 10;
            default: return 16;
        endcase
    endfunction

    function automatic string req_for(input logic [1:0] s);
        case (s)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // Starts at a negedge where fifo_rd is high; ends at the next such negedge.
    task automatic run_frame(input logic [1:0] sel, input logic [15:0] word,
                             input logic [15:0] exp, input string req,
                             input int mid_at, input logic [1:0] mid_sel);
        int n = bits_for(sel);
        ratio_sel = sel;
        par_in    = word;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, 32'(ser_data), 32'(exp[15-i]));
            chk("R7", 32'(par_clk), 32'(i < n/2));
            chk("R6", 32'(fifo_rd), 32'(i == n-1));
            if (!diag_loop_n) chk("R10", 32'(loop_data), 32'(exp[15-i]));
            else              chk("R10", 32'(loop_data), 32'd0);
            par_in = ~word; // R5: lanes only matter at the strobe edge
            if (i == mid_at) ratio_sel = mid_sel;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        mismatched++;
        $display("FAIL R6 watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ratio_sel = 2'b11; par_in = 16'hFFFF;
        lin_loop_n = 1'b1; diag_loop_n = 1'b1; ext_ser_data = 1'b0; ext_ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", 32'(ser_data), 32'd0);
        chk("R11", 32'(fifo_rd), 32'd0);
        chk("R11", 32'(par_clk), 32'd1);
        chk("R11", 32'(loop_data), 32'd0);
        rst_n = 1'b1;
        // R6/R7: first frame after reset is 16 bits of zeros
        for (int i = 1; i < 16; i++) begin
            @(negedge clk);
            chk("R6", 32'(fifo_rd), 32'(i == 15));
            chk("R7", 32'(par_clk), 32'(i < 8));
            chk("R11", 32'(ser_data), 32'd0);
        end
        // Vector table: every ratio, windows and outside lanes
        for (int k = 0; k < NVEC; k++) begin
            diag_loop_n = (k % 2 == 0);
            run_frame(VEC[k][33:32], VEC[k][31:16], VEC[k][15:0],
                      req_for(VEC[k][33:32]), -1, 2'b00);
        end
        diag_loop_n = 1'b1;
        // R8: select changes mid-frame; frame keeps 16 bits
        run_frame(2'b11, 16'hC3A5, 16'hC3A5, "R8", 2, 2'b00);
        run_frame(2'b00, 16'h03C0, 16'hF000, "R8", -1, 2'b00);
        // R8: change coincident with strobe, 10 then 8
        run_frame(2'b10, 16'h1008, 16'h8040, "R8", -1, 2'b00);
        run_frame(2'b01, 16'h0A50, 16'hA500, "R8", -1, 2'b00);
        // R9: line loopback
        lin_loop_n = 1'b0; ext_ser_data = 1'b1; ext_ser_clk = 1'b1;
        #1;
        chk("R9", 32'(ser_data), 32'd1);
        chk("R9", 32'(ser_clk), 32'd1);
        @(posedge clk); #(CLK_PERIOD/4);
        ext_ser_data = 1'b0; ext_ser_clk = 1'b0;
        #1;
        chk("R9", 32'(ser_data), 32'd0);
        chk("R9", 32'(ser_clk), 32'd0);
        // R10: mirror clock with loopbacks both on, then off
        diag_loop_n = 1'b0;
        @(posedge clk); #(CLK_PERIOD/4);
        chk("R10", 32'(loop_clk), 32'd1);
        diag_loop_n = 1'b1;
        #1;
        chk("R10", 32'(loop_clk), 32'd0);
        chk("R10", 32'(loop_data), 32'd0);
        // R4: serial clock follows bit clock with line loopback off
        lin_loop_n = 1'b1;
        @(posedge clk); #(CLK_PERIOD/4);
        chk("R4", 32'(ser_clk), 32'd1);
        @(negedge clk); #(CLK_PERIOD/4);
        chk("R4", 32'(ser_clk), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule